// File: doc/BRIEF.md
# SCSI Attention and Receive Parity Controller

This block drives the attention line of a parallel SCSI controller and checks the parity of bytes received from the bus. A small control register chooses four things: whether attention is raised while a target is being selected, whether received parity is checked, whether a parity error raises attention on its own, and whether the controller acts as target or as initiator. Selection progress, selection timeout, byte-received strobes, phase changes and bus reset reach the block as single-cycle input pulses. Bus phase sequencing, arbitration and the electrical interface are handled elsewhere.

When a received byte fails the odd-parity check and checking is enabled, a sticky status bit is set. That bit drives a maskable interrupt request. In initiator mode the block can also raise attention one cycle after the failing byte is strobed in, which is before the handshake for that byte releases acknowledge. The transfer is not stopped. Attention stays up until the target changes bus phase or the bus is reset.

Top module: `scsi_atn_par_ctl`

## Requirements
- R1: After a synchronous reset, ctl_o, sel_o, atn_o, perr_sts_o and irq_o are all 0.
- R2: A cfg_wr pulse stores wr_data bits 4 (select-with-attention), 3 (parity enable), 1 (attention on parity error) and 0 (target mode, 1 = target). It shows them on ctl_o after the next edge. Bit 2 and bits 7..5 always read back as 0.
- R3: When select-with-attention is set and target mode is clear, a sel_start pulse raises both sel_o and atn_o one cycle later.
- R4: When select-with-attention is clear, or when target mode is set, sel_start raises sel_o but leaves atn_o low.
- R5: A sel_timeout pulse drops sel_o and the selection attention on the same edge. A sel_done pulse drops only sel_o.
- R6: With parity enable set, a received byte is in error when the XOR of its 8 data bits and its parity bit is 0. An error sets perr_sts_o on the edge that strobes the byte in. This holds in both initiator and target mode.
- R7: With parity enable clear, a bad byte leaves perr_sts_o unchanged.
- R8: perr_sts_o stays set until an sts_wr pulse arrives with wr_data bit 0 = 1. An sts_wr pulse with bit 0 = 0 has no effect. A new error in the same cycle as the clear wins, and the bit stays set.
- R9: irq_o equals perr_sts_o ANDed with the irq_mask value that was present at the same edge.
- R10: With parity enable and attention-on-error both set, in initiator mode, a bad byte raises atn_o one cycle after rx_valid. This is before the acknowledge release of that byte.
- R11: In target mode, or when either enable bit is clear, a parity error never raises atn_o.
- R12: Attention raised by a parity error, or left over from selection, stays up through later good bytes. It falls only on phase_chg or bus_rst. bus_rst also drops sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| sts_wr | input | 1 | Write-one-to-clear strobe for the status bit |
| wr_data | input | 8 | Write data for both strobes |
| irq_mask | input | 1 | Interrupt enable for the parity status |
| sel_start | input | 1 | Selection of a target begins |
| sel_done | input | 1 | Target answered the selection |
| sel_timeout | input | 1 | Selection timed out |
| rx_valid | input | 1 | A received byte is present on rx_data/rx_par |
| rx_data | input | 8 | Received data byte |
| rx_par | input | 1 | Received parity bit |
| phase_chg | input | 1 | Target changed bus phase |
| bus_rst | input | 1 | Bus reset seen |
| ctl_o | output | 8 | Control register image |
| sel_o | output | 1 | Selection line drive |
| atn_o | output | 1 | Attention line drive |
| perr_sts_o | output | 1 | Sticky parity error status |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench sends both odd-parity-correct and incorrect bytes (for example 0x01/0 compared with 0x03/0 and 0x7F/1) under every relevant control setting: checking disabled, checking alone, checking with auto-attention, and target mode. This shows whether the error detection, the status bit and the attention path each depend on the right enable bits. Selection is run to a normal answer, to a timeout, and with the attention request masked by target mode, so that the sel_o and atn_o release conditions are told apart. Clears are applied with bit 0 set and clear, and together with a fresh error. The mask is toggled while the status is set, which separates the sticky bit from the interrupt.

// File: rtl/scsi_ap_pkg.sv
package scsi_ap_pkg;
  localparam int BIT_SEL_ATN  = 4;
  localparam int BIT_PAR_EN   = 3;
  localparam int BIT_ATN_PERR = 1;
  localparam int BIT_TGT      = 0;

  typedef struct packed {
    logic sel_atn;
    logic par_en;
    logic atn_perr;
    logic tgt;
  } ap_ctl_t;
endpackage

// File: rtl/scsi_ap_ctlreg.sv
module scsi_ap_ctlreg
  import scsi_ap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output ap_ctl_t       ctl,
  output logic [DW-1:0] img
);
  localparam logic [DW-1:0] KEEP = (DW'(1) << BIT_SEL_ATN) | (DW'(1) << BIT_PAR_EN) |
                                   (DW'(1) << BIT_ATN_PERR) | (DW'(1) << BIT_TGT);

  logic [DW-1:0] img_q;

  always_ff @(posedge clk) begin
    if (rst)     img_q <= '0;
    else if (wr) img_q <= wdata & KEEP;
  end

  assign img          = img_q;
  assign ctl.sel_atn  = img_q[BIT_SEL_ATN];
  assign ctl.par_en   = img_q[BIT_PAR_EN];
  assign ctl.atn_perr = img_q[BIT_ATN_PERR];
  assign ctl.tgt      = img_q[BIT_TGT];

  // R2: an unwritten register holds its value
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(img_q));
endmodule

// File: rtl/scsi_ap_parchk.sv
module scsi_ap_parchk #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          par,
  output logic          bad
);
  // odd parity: data bits plus parity must hold an odd count of ones
  assign bad = ~(^{data, par});
endmodule

// File: rtl/scsi_ap_atn.sv
module scsi_ap_atn
  import scsi_ap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ap_ctl_t ctl,
  input  logic    sel_start,
  input  logic    sel_done,
  input  logic    sel_timeout,
  input  logic    phase_chg,
  input  logic    bus_rst,
  input  logic    perr_hit,
  output logic    sel_o,
  output logic    atn_o
);
  logic sel_q, sel_d;
  logic satn_q, satn_d;
  logic patn_q, patn_d;
  logic atn_q;
  logic patn_set;

  assign patn_set = perr_hit && ctl.atn_perr && !ctl.tgt;

  always_comb begin
    sel_d = sel_q;
    if (bus_rst || sel_done || sel_timeout) sel_d = 1'b0;
    else if (sel_start)                     sel_d = 1'b1;

    satn_d = satn_q;
    if (bus_rst || phase_chg || sel_timeout)         satn_d = 1'b0;
    else if (sel_start && ctl.sel_atn && !ctl.tgt)   satn_d = 1'b1;

    patn_d = patn_q;
    if (patn_set)                  patn_d = 1'b1;
    else if (bus_rst || phase_chg) patn_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      satn_q <= 1'b0;
      patn_q <= 1'b0;
      atn_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      satn_q <= satn_d;
      patn_q <= patn_d;
      atn_q  <= satn_d | patn_d;
    end
  end

  assign sel_o = sel_q;
  assign atn_o = atn_q;

  // R5: a timeout releases selection and its attention on one edge
  a_r5_timeout_drop: assert property (@(posedge clk) disable iff (rst)
    sel_timeout && !bus_rst |=> !sel_q && !satn_q);
  // R10: qualified parity error raises attention on the next edge
  a_r10_auto_atn: assert property (@(posedge clk) disable iff (rst)
    perr_hit && ctl.atn_perr && !ctl.tgt |=> atn_q);
  // R11: target mode never starts parity attention
  a_r11_no_tgt_atn: assert property (@(posedge clk) disable iff (rst)
    $rose(patn_q) |-> !$past(ctl.tgt));
  // R12: parity attention holds until phase change or bus reset
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    patn_q && !phase_chg && !bus_rst |=> patn_q && atn_q);
endmodule

// File: rtl/scsi_ap_ists.sv
module scsi_ap_ists (
  input  logic clk,
  input  logic rst,
  input  logic err_set,
  input  logic clr_wr,
  input  logic clr_bit,
  input  logic mask,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q, sts_d, irq_q;

  always_comb begin
    sts_d = sts_q;
    if (err_set)               sts_d = 1'b1;
    else if (clr_wr && clr_bit) sts_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= sts_d & mask;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;

  // R8: status only falls on a write-one clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    sts_q && !(clr_wr && clr_bit) |=> sts_q);
  // R9: no request without status
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> sts_q);
endmodule

// File: rtl/scsi_atn_par_ctl.sv
module scsi_atn_par_ctl
  import scsi_ap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          sts_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_mask,
  input  logic          sel_start,
  input  logic          sel_done,
  input  logic          sel_timeout,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par,
  input  logic          phase_chg,
  input  logic          bus_rst,
  output logic [DW-1:0] ctl_o,
  output logic          sel_o,
  output logic          atn_o,
  output logic          perr_sts_o,
  output logic          irq_o
);
  ap_ctl_t ctl;
  logic    par_bad;
  logic    perr_hit;

  scsi_ap_ctlreg #(.DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(wr_data), .ctl(ctl), .img(ctl_o)
  );

  scsi_ap_parchk #(.DW(DW)) u_par (
    .data(rx_data), .par(rx_par), .bad(par_bad)
  );

  assign perr_hit = rx_valid && par_bad && ctl.par_en;

  scsi_ap_atn u_atn (
    .clk(clk), .rst(rst), .ctl(ctl),
    .sel_start(sel_start), .sel_done(sel_done), .sel_timeout(sel_timeout),
    .phase_chg(phase_chg), .bus_rst(bus_rst), .perr_hit(perr_hit),
    .sel_o(sel_o), .atn_o(atn_o)
  );

  scsi_ap_ists u_sts (
    .clk(clk), .rst(rst), .err_set(perr_hit), .clr_wr(sts_wr),
    .clr_bit(wr_data[0]), .mask(irq_mask), .sts_o(perr_sts_o), .irq_o(irq_o)
  );

  // R7: status never rises while checking is disabled
  a_r7_no_check: assert property (@(posedge clk) disable iff (rst)
    $rose(perr_sts_o) |-> $past(ctl.par_en));
endmodule

// File: tb/scsi_atn_par_ctl_tb_top.sv
module scsi_atn_par_ctl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       cfg_wr = 0, sts_wr = 0, irq_mask = 0;
  logic [7:0] wr_data = 0, rx_data = 0;
  logic       sel_start = 0, sel_done = 0, sel_timeout = 0;
  logic       rx_valid = 0, rx_par = 0, phase_chg = 0, bus_rst = 0;
  logic [7:0] ctl_o;
  logic       sel_o, atn_o, perr_sts_o, irq_o;

  scsi_atn_par_ctl dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .sts_wr(sts_wr), .wr_data(wr_data),
    .irq_mask(irq_mask), .sel_start(sel_start), .sel_done(sel_done),
    .sel_timeout(sel_timeout), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par(rx_par), .phase_chg(phase_chg), .bus_rst(bus_rst),
    .ctl_o(ctl_o), .sel_o(sel_o), .atn_o(atn_o), .perr_sts_o(perr_sts_o), .irq_o(irq_o)
  );

  typedef struct {
    logic       atn, sel, sts, irq;
    logic [7:0] ctl;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  // driver: inputs are already set; take one edge and queue the expectation
  task automatic step(input logic ea, input logic es, input logic est,
                      input logic ei, input logic [7:0] ec, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.atn = ea; e.sel = es; e.sts = est; e.irq = ei; e.ctl = ec; e.tag = tag;
    q.push_back(e);
    cfg_wr = 0; sts_wr = 0; sel_start = 0; sel_done = 0; sel_timeout = 0;
    rx_valid = 0; phase_chg = 0; bus_rst = 0;
  endtask

  task automatic byte_in(input logic [7:0] d, input logic p);
    rx_valid = 1; rx_data = d; rx_par = p;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (atn_o !== e.atn || sel_o !== e.sel || perr_sts_o !== e.sts ||
          irq_o !== e.irq || ctl_o !== e.ctl) begin
        n_bad++;
        $display("FAIL %s: got atn=%b sel=%b sts=%b irq=%b ctl=%h, exp atn=%b sel=%b sts=%b irq=%b ctl=%h",
                 e.tag, atn_o, sel_o, perr_sts_o, irq_o, ctl_o,
                 e.atn, e.sel, e.sts, e.irq, e.ctl);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: got hung run, exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    step(0,0,0,0,8'h00,"R1 reset");
    step(0,0,0,0,8'h00,"R1 reset");
    rst = 0;
    step(0,0,0,0,8'h00,"R1 after reset");

    // R2 and R4 in target mode
    cfg_wr = 1; wr_data = 8'hFF;         step(0,0,0,0,8'h1B,"R2 masked write");
    sel_start = 1;                       step(0,1,0,0,8'h1B,"R4 target sel no atn");
    sel_done = 1;                        step(0,0,0,0,8'h1B,"R5 sel_done");

    // R3 / R5 selection with attention
    cfg_wr = 1; wr_data = 8'h10;         step(0,0,0,0,8'h10,"R2 write sel_atn");
    sel_start = 1;                       step(1,1,0,0,8'h10,"R3 sel atn");
    step(1,1,0,0,8'h10,"R3 sel atn held");
    sel_timeout = 1;                     step(0,0,0,0,8'h10,"R5 timeout drop");
    sel_start = 1;                       step(1,1,0,0,8'h10,"R3 sel again");
    sel_done = 1;                        step(1,0,0,0,8'h10,"R5 done keeps atn");
    phase_chg = 1;                       step(0,0,0,0,8'h10,"R12 phase clears sel atn");

    // R4 select-with-attention clear
    cfg_wr = 1; wr_data = 8'h00;         step(0,0,0,0,8'h00,"R2 clear");
    sel_start = 1;                       step(0,1,0,0,8'h00,"R4 no sel atn");
    bus_rst = 1;                         step(0,0,0,0,8'h00,"R12 bus_rst drops sel");

    // R7 checking disabled
    irq_mask = 1;
    byte_in(8'h00, 0);                   step(0,0,0,0,8'h00,"R7 disabled");

    // R6 checking only
    cfg_wr = 1; wr_data = 8'h08;         step(0,0,0,0,8'h08,"R2 par_en");
    byte_in(8'h01, 0);                   step(0,0,0,0,8'h08,"R6 good byte");
    byte_in(8'h03, 0);                   step(0,0,1,1,8'h08,"R6 bad byte R11 no atn");
    sts_wr = 1; wr_data = 8'h00;         step(0,0,1,1,8'h08,"R8 clear bit0=0 ignored");
    sts_wr = 1; wr_data = 8'h01;         step(0,0,0,0,8'h08,"R8 clear");

    // R9 mask
    irq_mask = 0;
    byte_in(8'h03, 0);                   step(0,0,1,0,8'h08,"R9 masked");
    irq_mask = 1;                        step(0,0,1,1,8'h08,"R9 unmasked");
    sts_wr = 1; wr_data = 8'h01;         step(0,0,0,0,8'h08,"R8 clear");

    // R10 / R12 auto attention
    cfg_wr = 1; wr_data = 8'h0A;         step(0,0,0,0,8'h0A,"R2 par_en+auto");
    byte_in(8'h7F, 1);                   step(1,0,1,1,8'h0A,"R10 auto atn");
    byte_in(8'h01, 0);                   step(1,0,1,1,8'h0A,"R12 held over good byte");
    step(1,0,1,1,8'h0A,"R12 held idle");
    phase_chg = 1;                       step(0,0,1,1,8'h0A,"R12 phase drop");
    sts_wr = 1; wr_data = 8'h01;         step(0,0,0,0,8'h0A,"R8 clear");
    byte_in(8'hFE, 1);                   step(1,0,1,1,8'h0A,"R10 auto atn 2");
    bus_rst = 1;                         step(0,0,1,1,8'h0A,"R12 bus_rst drop");

    // R8 set wins over clear
    sts_wr = 1; wr_data = 8'h01; byte_in(8'h00, 0);
                                         step(1,0,1,1,8'h0A,"R8 set wins");
    phase_chg = 1;                       step(0,0,1,1,8'h0A,"R12 drop");
    sts_wr = 1; wr_data = 8'h01;         step(0,0,0,0,8'h0A,"R8 clear");

    // R11 target mode with both enables
    cfg_wr = 1; wr_data = 8'h0B;         step(0,0,0,0,8'h0B,"R2 target");
    byte_in(8'h03, 0);                   step(0,0,1,1,8'h0B,"R11 target no atn R6");
    step(0,0,1,1,8'h0B,"R11 target idle");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule